// File: doc/BRIEF.md
# Secure Interrupt Router

The router collects 32 interrupt sources and delivers each pending one to any of four processors, either on that processor's normal-interrupt line or on its fast-interrupt line. Every source holds a separate setting for each processor: a two-bit priority, a one-bit type that picks normal or fast delivery, and a one-bit security flag. A source with a rising input edge becomes pending and stays pending until software clears it.

Software reaches the block through a plain synchronous register port: one enable, one write flag, an address, write data, and a secure-access flag that qualifies every transaction. Read data is registered and appears one cycle after the read. Set and clear aliases of the control and configuration registers let software change single bits without a read-modify-write. Security gating hides secured sources from non-secure software and stops non-secure software from changing them. A lock bit extends the same protection to the control bits.

A small state machine runs the soft-reset sequence. It starts in `ST_RUN`. A permitted write of 1 to the soft-reset bit moves it to `ST_WIPE`, where pending and configuration state is held at zero for `WIPE_CYCLES` cycles. It then moves to `ST_RELEASE` for one cycle and goes back to `ST_RUN`, and at that point the soft-reset bit reads 0 again. A debug port reports the most urgent pending source.

Top module: `irq_router`

## Requirements
- R1: After reset, all pending bits, configuration registers and control bits are 0, every interrupt output and the debug valid flag are low, and reads return 0.
- R2: A source becomes pending on the cycle after its input goes from 0 to 1. It stays pending until cleared. An input that is held high does not make the source pending again after a clear.
- R3: Offset 0x10 reads the pending bits, with bit i for source i. Writing 1s at offset 0x18 clears those pending bits. If a new edge arrives in the same cycle as its clear, the edge wins.
- R4: Source i has a 16-bit configuration register at 0x20 + i*0x10. For processor n, bits [4n+3:4n+2] are the priority, bit 4n+1 is the type (0 normal, 1 fast) and bit 4n is the security flag. A write at +0 replaces the value, a write at +4 ORs bits in, and a write at +8 clears the bits written as 1.
- R5: `irq_o[n]` is high when some pending source has a non-zero priority and type 0 for processor n. `fiq_o[n]` is the same for type 1. Priority 0 masks the source for that processor.
- R6: A source is secured when any of its security flags is set. A non-secure read of 0x10 or 0x18 returns 0 for secured sources, and a non-secure clear leaves their pending bits set.
- R7: A non-secure configuration write leaves the 4-bit group of processor n unchanged when that group's security flag is 1. Secure writes always apply.
- R8: The control register sits at 0x0, with set alias 0x4 and clear alias 0x8. Bit 7 is freeze, bit 6 is soft-reset and bit 5 is lock. Only a secure write may change the lock bit.
- R9: While lock is 1, a non-secure write changes neither the freeze bit nor the soft-reset bit.
- R10: While freeze is 1, no new pending bit is captured, and edges that arrive in that time are dropped.
- R11: A permitted write of 1 to bit 6 (at 0x0 or 0x4) clears all pending and configuration state. Bit 6 reads 1 for WIPE_CYCLES+1 cycles and then returns to 0. Bus writes in that time are ignored, and freeze and lock are kept.
- R12: The debug port gives the pending source with the highest level, where a source's level is its largest priority over all processors (3 > 2 > 1). The lowest source number wins a tie. `dbg_valid_o` is low when no pending source has a non-zero level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source inputs, rising-edge captured |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_secure_i | input | 1 | Access is secure |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the cycle after a read |
| irq_o | output | NUM_CPU | Normal interrupt per processor |
| fiq_o | output | NUM_CPU | Fast interrupt per processor |
| dbg_valid_o | output | 1 | A routable source is pending |
| dbg_src_o | output | $clog2(NUM_SRC) | Most urgent pending source |
| dbg_level_o | output | 2 | Level of that source |

## Verification
The assertions assume that the source inputs are synchronous to `clk_i`, that a bus strobe lasts one cycle with its address and data stable on that cycle, and that the secure flag is valid whenever the strobe is high. The stimulus changes every input on the falling edge, pulses each strobe for a single cycle, and raises source inputs for one cycle at a time, except in the held-level test. This keeps every edge and every access clean at the sampling edge.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int GRP_W        = 4;
    localparam int FREEZE_BIT   = 7;
    localparam int WIPE_BIT     = 6;
    localparam int LOCK_BIT     = 5;
    localparam int OFS_STAT     = 'h10;
    localparam int OFS_STAT_CLR = 'h18;
    localparam int OFS_CFG_BASE = 'h20;
    localparam int CFG_SLOT_LG  = 4;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_WIPE,
        ST_RELEASE
    } wipe_state_e;

    typedef enum logic [1:0] {
        AL_PLAIN,
        AL_SET,
        AL_CLR,
        AL_NONE
    } alias_e;

    function automatic alias_e alias_of(input logic [3:0] low);
        case (low)
            4'h0:    return AL_PLAIN;
            4'h4:    return AL_SET;
            4'h8:    return AL_CLR;
            default: return AL_NONE;
        endcase
    endfunction

    function automatic logic [GRP_W-1:0] merge_grp(input logic [GRP_W-1:0] cur,
                                                   input logic [GRP_W-1:0] wr,
                                                   input alias_e al);
        case (al)
            AL_PLAIN: return wr;
            AL_SET:   return cur | wr;
            AL_CLR:   return cur & ~wr;
            default:  return cur;
        endcase
    endfunction

    function automatic logic merge_bit(input logic cur, input logic wr, input alias_e al);
        case (al)
            AL_PLAIN: return wr;
            AL_SET:   return cur | wr;
            AL_CLR:   return cur & ~wr;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               freeze_i,
    input  logic               wipe_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);

    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] rise;

    assign rise = src_i & ~prev_q;

    // Edge capture; a fresh edge beats a clear in the same cycle.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= src_i;
            if (wipe_i) begin
                pend_q <= '0;
            end else begin
                pend_q <= (pend_q & ~clr_i) | (freeze_i ? '0 : rise);
            end
        end
    end

    assign pend_o = pend_q;

    // R2: an unfrozen edge is pending on the next cycle
    p_edge_captured_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!freeze_i && !wipe_i) |=> (($past(rise) & ~pend_q) == '0));

    // R10: freeze admits no new pending bit
    p_freeze_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (freeze_i && !wipe_i) |=> ((pend_q & ~$past(pend_q)) == '0));

    // R11: the wipe empties the pending set
    p_wipe_empty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wipe_i |=> (pend_q == '0));

endmodule

// File: rtl/irq_route.sv
module irq_route
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4,
    localparam int CFG_W  = GRP_W * NUM_CPU
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [NUM_SRC-1:0]            pend_i,
    input  logic [NUM_SRC-1:0][CFG_W-1:0] cfg_i,
    output logic [NUM_CPU-1:0]            irq_o,
    output logic [NUM_CPU-1:0]            fiq_o
);

    for (genvar n = 0; n < NUM_CPU; n++) begin : g_cpu
        logic [NUM_SRC-1:0] want_norm;
        logic [NUM_SRC-1:0] want_fast;

        always_comb begin
            for (int i = 0; i < NUM_SRC; i++) begin
                want_norm[i] = pend_i[i] && (cfg_i[i][GRP_W*n+2 +: 2] != 2'd0) && !cfg_i[i][GRP_W*n+1];
                want_fast[i] = pend_i[i] && (cfg_i[i][GRP_W*n+2 +: 2] != 2'd0) &&  cfg_i[i][GRP_W*n+1];
            end
        end

        assign irq_o[n] = |want_norm;
        assign fiq_o[n] = |want_fast;
    end

    // R5: nothing pending means every line is quiet
    p_quiet_lines_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_i == '0) |-> (irq_o == '0 && fiq_o == '0));

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4,
    localparam int CFG_W  = GRP_W * NUM_CPU,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [NUM_SRC-1:0]            pend_i,
    input  logic [NUM_SRC-1:0][CFG_W-1:0] cfg_i,
    output logic                          valid_o,
    output logic [SRC_W-1:0]              src_o,
    output logic [1:0]                    level_o
);

    logic [1:0]       best_lvl;
    logic [SRC_W-1:0] best_idx;
    logic [1:0]       lvl;

    // Strict comparison keeps the lowest index on a tie.
    always_comb begin
        best_lvl = 2'd0;
        best_idx = '0;
        lvl      = 2'd0;
        for (int i = 0; i < NUM_SRC; i++) begin
            lvl = 2'd0;
            for (int n = 0; n < NUM_CPU; n++) begin
                if (pend_i[i] && (cfg_i[i][GRP_W*n+2 +: 2] > lvl)) begin
                    lvl = cfg_i[i][GRP_W*n+2 +: 2];
                end
            end
            if (lvl > best_lvl) begin
                best_lvl = lvl;
                best_idx = SRC_W'(i);
            end
        end
    end

    assign valid_o = (best_lvl != 2'd0);
    assign src_o   = best_idx;
    assign level_o = best_lvl;

    // R12: the reported source is really pending
    p_pick_pending_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> pend_i[src_o]);

    // R12: an empty pending set gives no report
    p_pick_empty_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_i == '0) |-> !valid_o);

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int NUM_CPU     = 4,
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter int WIPE_CYCLES = 4,
    localparam int SRC_W      = $clog2(NUM_SRC)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_en_i,
    input  logic               bus_we_i,
    input  logic               bus_secure_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic [NUM_CPU-1:0] irq_o,
    output logic [NUM_CPU-1:0] fiq_o,
    output logic               dbg_valid_o,
    output logic [SRC_W-1:0]   dbg_src_o,
    output logic [1:0]         dbg_level_o
);

    localparam int CFG_W  = GRP_W * NUM_CPU;
    localparam int SLOT_W = ADDR_W - CFG_SLOT_LG;
    localparam int CNT_W  = $clog2(WIPE_CYCLES + 1);

    // ---------------- state ----------------
    wipe_state_e               st_q, st_d;
    logic [CNT_W-1:0]          cnt_q, cnt_d;
    logic                      freeze_q, lock_q;
    logic [NUM_SRC-1:0][CFG_W-1:0] cfg_q;
    logic [CFG_W-1:0]          cfg_next;
    logic [NUM_SRC-1:0]        pend;
    logic [NUM_SRC-1:0]        sec_mask;
    logic [NUM_SRC-1:0]        clr_mask;
    logic [DATA_W-1:0]         rd_val;
    logic [DATA_W-1:0]         rdata_q;

    // ---------------- decode ----------------
    alias_e             bus_alias;
    logic [ADDR_W-1:0]  cfg_off;
    logic [SRC_W-1:0]   cfg_idx;
    logic               ctrl_hit, stat_hit, stat_clr_hit, cfg_hit;
    logic               wr_ok, ctl_may, wipe_req, wipe_active, wipe_busy;

    always_comb begin
        bus_alias    = alias_of(bus_addr_i[3:0]);
        cfg_off      = bus_addr_i - ADDR_W'(OFS_CFG_BASE);
        cfg_idx      = cfg_off[CFG_SLOT_LG +: SRC_W];
        ctrl_hit     = (bus_addr_i[ADDR_W-1:CFG_SLOT_LG] == '0) && (bus_alias != AL_NONE);
        stat_hit     = (bus_addr_i == ADDR_W'(OFS_STAT));
        stat_clr_hit = (bus_addr_i == ADDR_W'(OFS_STAT_CLR));
        cfg_hit      = (bus_addr_i >= ADDR_W'(OFS_CFG_BASE))
                    && (cfg_off[ADDR_W-1:CFG_SLOT_LG] < SLOT_W'(NUM_SRC))
                    && (bus_alias != AL_NONE);
        wr_ok        = bus_en_i && bus_we_i && (st_q == ST_RUN);
        ctl_may      = bus_secure_i || !lock_q;
        wipe_req     = wr_ok && ctrl_hit && ctl_may && bus_wdata_i[WIPE_BIT]
                    && ((bus_alias == AL_PLAIN) || (bus_alias == AL_SET));
    end

    // ---------------- soft-reset state machine ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_RUN: begin
                if (wipe_req) begin
                    st_d  = ST_WIPE;
                    cnt_d = '0;
                end
            end
            ST_WIPE: begin
                if (cnt_q == CNT_W'(WIPE_CYCLES - 1)) begin
                    st_d = ST_RELEASE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RELEASE: st_d = ST_RUN;
            default:    st_d = ST_RUN;
        endcase
    end

    always_comb begin
        wipe_active = (st_q == ST_WIPE);
        wipe_busy   = (st_q != ST_RUN);
    end

    // ---------------- control bits ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            freeze_q <= 1'b0;
            lock_q   <= 1'b0;
        end else if (wr_ok && ctrl_hit) begin
            if (ctl_may) begin
                freeze_q <= merge_bit(freeze_q, bus_wdata_i[FREEZE_BIT], bus_alias);
            end
            if (bus_secure_i) begin
                lock_q <= merge_bit(lock_q, bus_wdata_i[LOCK_BIT], bus_alias);
            end
        end
    end

    // ---------------- configuration ----------------
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            sec_mask[i] = 1'b0;
            for (int n = 0; n < NUM_CPU; n++) begin
                sec_mask[i] = sec_mask[i] | cfg_q[i][GRP_W*n];
            end
        end
    end

    always_comb begin
        cfg_next = cfg_q[cfg_idx];
        for (int n = 0; n < NUM_CPU; n++) begin
            if (bus_secure_i || !cfg_q[cfg_idx][GRP_W*n]) begin
                cfg_next[GRP_W*n +: GRP_W] = merge_grp(cfg_q[cfg_idx][GRP_W*n +: GRP_W],
                                                       bus_wdata_i[GRP_W*n +: GRP_W], bus_alias);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else if (wipe_active) begin
            cfg_q <= '0;
        end else if (wr_ok && cfg_hit) begin
            cfg_q[cfg_idx] <= cfg_next;
        end
    end

    // ---------------- pending, routing, debug ----------------
    assign clr_mask = (wr_ok && stat_clr_hit)
                    ? (bus_wdata_i[NUM_SRC-1:0] & (bus_secure_i ? '1 : ~sec_mask))
                    : '0;

    irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .src_i    (src_i),
        .freeze_i (freeze_q),
        .wipe_i   (wipe_active),
        .clr_i    (clr_mask),
        .pend_o   (pend)
    );

    irq_route #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_route (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pend_i (pend),
        .cfg_i  (cfg_q),
        .irq_o  (irq_o),
        .fiq_o  (fiq_o)
    );

    irq_pick #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_pick (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pend_i  (pend),
        .cfg_i   (cfg_q),
        .valid_o (dbg_valid_o),
        .src_o   (dbg_src_o),
        .level_o (dbg_level_o)
    );

    // ---------------- read path ----------------
    always_comb begin
        rd_val = '0;
        if (ctrl_hit) begin
            rd_val[FREEZE_BIT] = freeze_q;
            rd_val[WIPE_BIT]   = wipe_busy;
            rd_val[LOCK_BIT]   = lock_q;
        end else if (stat_hit || stat_clr_hit) begin
            rd_val = DATA_W'(pend & (bus_secure_i ? '1 : ~sec_mask));
        end else if (cfg_hit) begin
            rd_val = DATA_W'(cfg_q[cfg_idx]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else if (bus_en_i && !bus_we_i) begin
            rdata_q <= rd_val;
        end
    end

    assign bus_rdata_o = rdata_q;

    // ---------------- assertions ----------------
    // R6: non-secure status reads never expose secured sources
    p_hide_secured_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_en_i && !bus_we_i && !bus_secure_i && (stat_hit || stat_clr_hit))
        |=> ((bus_rdata_o[NUM_SRC-1:0] & $past(sec_mask)) == '0));

    // R6: a non-secure clear leaves secured pending bits alone
    p_keep_secured_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_ok && stat_clr_hit && !bus_secure_i)
        |=> (($past(pend & sec_mask) & ~pend) == '0));

    // R8: only a secure write moves the lock bit
    p_lock_secure_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_en_i && bus_we_i && !bus_secure_i) |=> $stable(lock_q));

    // R9: locked control bits ignore non-secure writes
    p_lock_guard_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_ok && ctrl_hit && !bus_secure_i && lock_q)
        |=> ($stable(freeze_q) && st_q == ST_RUN));

    // R11: writes during the wipe leave the configuration cleared
    p_wipe_cfg_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wipe_active |=> (cfg_q == '0));

endmodule

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [1:0]  op;     // 0 write, 1 read-check, 2 source pulse, 3 output-check
        logic        sec;
        logic [9:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // Output observation word: irq[3:0], fiq[7:4], dbg_src[12:8], dbg_level[14:13], dbg_valid[15]
    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 10'h020, 32'h0000_0004, 32'h0, 4'd4},   // R4 plain write
        '{2'd1, 1'b0, 10'h020, 32'h0, 32'h0000_0004, 4'd4},
        '{2'd0, 1'b0, 10'h024, 32'h0000_0060, 32'h0, 4'd4},   // R4 set alias
        '{2'd1, 1'b0, 10'h020, 32'h0, 32'h0000_0064, 4'd4},
        '{2'd0, 1'b0, 10'h028, 32'h0000_0004, 32'h0, 4'd4},   // R4 clear alias
        '{2'd1, 1'b0, 10'h020, 32'h0, 32'h0000_0060, 4'd4},
        '{2'd0, 1'b0, 10'h024, 32'h0000_0004, 32'h0, 4'd4},
        '{2'd2, 1'b0, 10'h000, 32'h0000_0001, 32'h0, 4'd2},   // R2 edge on source 0
        '{2'd3, 1'b0, 10'h000, 32'h0, 32'h0000_A021, 4'd5},   // R5 normal cpu0, fast cpu1
        '{2'd1, 1'b0, 10'h010, 32'h0, 32'h0000_0001, 4'd3},   // R3 status
        '{2'd0, 1'b0, 10'h070, 32'h0000_0800, 32'h0, 4'd4},
        '{2'd2, 1'b0, 10'h000, 32'h0000_0020, 32'h0, 4'd2},
        '{2'd3, 1'b0, 10'h000, 32'h0, 32'h0000_C525, 4'd12},  // R12 higher level wins
        '{2'd0, 1'b0, 10'h050, 32'h0000_0002, 32'h0, 4'd4},
        '{2'd2, 1'b0, 10'h000, 32'h0000_0008, 32'h0, 4'd2},
        '{2'd3, 1'b0, 10'h000, 32'h0, 32'h0000_C525, 4'd5},   // R5 masked source silent
        '{2'd1, 1'b0, 10'h010, 32'h0, 32'h0000_0029, 4'd3},
        '{2'd0, 1'b0, 10'h018, 32'h0000_0021, 32'h0, 4'd3},   // R3 clear alias
        '{2'd1, 1'b0, 10'h010, 32'h0, 32'h0000_0008, 4'd3},
        '{2'd3, 1'b0, 10'h000, 32'h0, 32'h0000_0000, 4'd5},
        '{2'd0, 1'b0, 10'h090, 32'h0000_0008, 32'h0, 4'd4},
        '{2'd0, 1'b0, 10'h0B0, 32'h0000_0080, 32'h0, 4'd4},
        '{2'd2, 1'b0, 10'h000, 32'h0000_0280, 32'h0, 4'd2},
        '{2'd3, 1'b0, 10'h000, 32'h0, 32'h0000_C703, 4'd12},  // R12 tie -> lower index
        '{2'd0, 1'b0, 10'h018, 32'hFFFF_FFFF, 32'h0, 4'd3},
        '{2'd1, 1'b0, 10'h010, 32'h0, 32'h0000_0000, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        bus_en = 1'b0, bus_we = 1'b0, bus_sec = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq, fiq;
    logic        dbg_valid;
    logic [4:0]  dbg_src;
    logic [1:0]  dbg_level;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_router dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .src_i        (src),
        .bus_en_i     (bus_en),
        .bus_we_i     (bus_we),
        .bus_secure_i (bus_sec),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .irq_o        (irq),
        .fiq_o        (fiq),
        .dbg_valid_o  (dbg_valid),
        .dbg_src_o    (dbg_src),
        .dbg_level_o  (dbg_level)
    );

    function automatic logic [31:0] observe();
        return {16'h0, dbg_valid, dbg_level, dbg_src, fiq, irq};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic sec, input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_sec = sec; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic sec, input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_sec = sec; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] m);
        @(negedge clk);
        src = src | m;
        @(negedge clk);
        src = src & ~m;
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 outputs", observe(), 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        bus_rd(1'b1, 10'h000, rd); chk("R1 ctrl", rd, 32'h0);
        bus_rd(1'b1, 10'h010, rd); chk("R1 status", rd, 32'h0);
        bus_rd(1'b1, 10'h020, rd); chk("R1 cfg0", rd, 32'h0);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            case (VECS[k].op)
                2'd0: bus_wr(VECS[k].sec, VECS[k].addr, VECS[k].data);
                2'd1: begin
                    bus_rd(VECS[k].sec, VECS[k].addr, rd);
                    chk($sformatf("R%0d vec%0d", VECS[k].req, k), rd, VECS[k].exp);
                end
                2'd2: pulse(VECS[k].data);
                default: begin
                    @(negedge clk);
                    chk($sformatf("R%0d vec%0d", VECS[k].req, k), observe(), VECS[k].exp);
                end
            endcase
        end

        // R2: held level does not re-pend after clear
        @(negedge clk); src[1] = 1'b1;
        bus_rd(1'b0, 10'h010, rd); chk("R2 level edge", rd, 32'h2);
        bus_wr(1'b0, 10'h018, 32'h2);
        bus_rd(1'b0, 10'h010, rd); chk("R2 held no retrigger", rd, 32'h0);
        @(negedge clk); src[1] = 1'b0;
        pulse(32'h2);
        bus_rd(1'b0, 10'h010, rd); chk("R2 new edge", rd, 32'h2);
        bus_wr(1'b0, 10'h018, 32'h2);

        // R6: secured source hidden and protected
        bus_wr(1'b1, 10'h040, 32'h0000_0001);
        pulse(32'h4);
        bus_rd(1'b0, 10'h010, rd); chk("R6 ns read hidden", rd, 32'h0);
        bus_rd(1'b1, 10'h010, rd); chk("R6 secure read", rd, 32'h4);
        bus_wr(1'b0, 10'h018, 32'h4);
        bus_rd(1'b1, 10'h018, rd); chk("R6 ns clear refused", rd, 32'h4);

        // R7: per-processor protection of configuration groups
        bus_wr(1'b0, 10'h040, 32'h0000_00F0);
        bus_rd(1'b1, 10'h040, rd); chk("R7 ns plain write", rd, 32'h0000_00F1);
        bus_wr(1'b0, 10'h048, 32'h0000_FFFF);
        bus_rd(1'b1, 10'h040, rd); chk("R7 ns clear alias", rd, 32'h0000_00F1);
        bus_wr(1'b1, 10'h048, 32'h0000_FFFF);
        bus_rd(1'b0, 10'h040, rd); chk("R7 secure clear", rd, 32'h0);
        bus_rd(1'b0, 10'h010, rd); chk("R6 unsecured visible", rd, 32'h4);
        bus_wr(1'b0, 10'h018, 32'h4);
        bus_rd(1'b0, 10'h010, rd); chk("R3 ns clear", rd, 32'h0);

        // R8 / R9: lock behaviour
        bus_wr(1'b0, 10'h004, 32'h20);
        bus_rd(1'b0, 10'h000, rd); chk("R8 ns cannot lock", rd, 32'h0);
        bus_wr(1'b1, 10'h004, 32'h20);
        bus_rd(1'b0, 10'h000, rd); chk("R8 secure lock", rd, 32'h20);
        bus_wr(1'b0, 10'h004, 32'h80);
        bus_rd(1'b0, 10'h000, rd); chk("R9 freeze blocked", rd, 32'h20);
        bus_wr(1'b0, 10'h000, 32'h40);
        bus_rd(1'b0, 10'h000, rd); chk("R9 soft reset blocked", rd, 32'h20);
        bus_wr(1'b0, 10'h008, 32'h20);
        bus_rd(1'b0, 10'h000, rd); chk("R8 ns cannot unlock", rd, 32'h20);
        bus_wr(1'b1, 10'h008, 32'h20);
        bus_rd(1'b0, 10'h000, rd); chk("R8 secure unlock", rd, 32'h0);

        // R10: freeze drops edges
        bus_wr(1'b0, 10'h004, 32'h80);
        bus_rd(1'b0, 10'h000, rd); chk("R10 freeze set", rd, 32'h80);
        pulse(32'h10);
        bus_rd(1'b0, 10'h010, rd); chk("R10 frozen", rd, 32'h0);
        bus_wr(1'b0, 10'h008, 32'h80);
        bus_rd(1'b0, 10'h010, rd); chk("R10 edge dropped", rd, 32'h0);
        pulse(32'h10);
        bus_rd(1'b0, 10'h010, rd); chk("R10 capture resumes", rd, 32'h10);

        // R11: soft reset sequence
        bus_wr(1'b1, 10'h000, 32'h60);
        bus_wr(1'b0, 10'h020, 32'h0000_0004);
        bus_rd(1'b1, 10'h000, rd); chk("R11 busy", rd, 32'h60);
        for (int p = 0; p < 20; p++) begin
            if (rd != 32'h60) break;
            bus_rd(1'b1, 10'h000, rd);
        end
        chk("R11 self clear keeps lock", rd, 32'h20);
        bus_rd(1'b1, 10'h010, rd); chk("R11 pending wiped", rd, 32'h0);
        bus_rd(1'b1, 10'h020, rd); chk("R11 cfg wiped", rd, 32'h0);
        @(negedge clk);
        chk("R11 outputs quiet", observe(), 32'h0);
        bus_wr(1'b1, 10'h008, 32'h20);

        summary();
        $finish;
    end

endmodule